// File: doc/BRIEF.md
# Inter-Agent Doorbell Interrupt Register Block

This block is a small register file on a 32-bit read/write port. Through it, one agent rings a doorbell on another agent, and it raises interrupts toward its own agent. A write to the doorbell word becomes an outgoing event that carries a destination ID and a vector. Events that arrive from peers are turned into local interrupts.

A mode input chooses how those interrupts are signalled. In pin mode, an incoming event sets a one-bit status flag, and a level interrupt is raised while that flag is set and unmasked. In message mode, each incoming event becomes a one-cycle pulse on one of `NUM_VEC` per-vector outputs. The status flag is not touched in that mode.

An identity word reports the agent's ID once the surrounding system reports ready. Until then it reads as all ones. In message mode, a doorbell write that names a vector outside the configured range is discarded, and a sticky error output records the drop.

Top module: `bell_regblock`

## Requirements
- R1: After reset the mask word and the status flag are 0, and the outputs `dropErr`, `outValid`, `irqPin` and `msgIrq` are all 0.
- R2: In pin mode (`msgMode`=0), an incoming event (`inValid`=1) makes the status word (word index 1) read as exactly 1 from the next cycle on, whatever vector the event carries.
- R3: The mask word (word index 0) holds all 32 written bits. `irqPin` is high exactly when the mode is pin mode and mask bit 0 and the status flag are both 1. The other mask bits have no effect.
- R4: In message mode (`msgMode`=1), an incoming event with vector v < `NUM_VEC` drives `msgIrq[v]` high for exactly the next cycle. An event with v >= `NUM_VEC` gives no pulse. In this mode the status flag never changes through events, and `irqPin` stays low.
- R5: The identity word (word index 2) reads `{16'h0, selfId}` while `devReady`=1 and 32'hFFFFFFFF while `devReady`=0. Writes to it have no effect.
- R6: An accepted write to the doorbell word (word index 3) raises `outValid` for exactly the next cycle. In that cycle `outDestId` carries write bits 31:16 and `outVector` carries write bits 15:0.
- R7: In pin mode, every doorbell write is accepted, whatever its low 16 bits hold.
- R8: In message mode, a doorbell write whose bits 15:0 are >= `NUM_VEC` produces no outgoing event and sets `dropErr`. `dropErr` stays set until reset.
- R9: A read of the status word returns the current flag and clears it at that clock edge. If an incoming pin-mode event arrives in the same cycle, the flag is 1 afterwards.
- R10: Writes to the status word are ignored, and reads of the doorbell word return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgMode | input | 1 | 0 = pin signalling, 1 = per-vector message pulses |
| devReady | input | 1 | High once the agent's ID is valid |
| selfId | input | 16 | This agent's assigned ID |
| busWordSel | input | 2 | Word index: 0 mask, 1 status, 2 identity, 3 doorbell |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (clears status when reading word 1) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the word index |
| outValid | output | 1 | One-cycle outgoing doorbell event |
| outDestId | output | 16 | Destination ID of the outgoing event |
| outVector | output | 16 | Vector of the outgoing event |
| inValid | input | 1 | Incoming event from a peer |
| inVector | input | 16 | Vector of the incoming event |
| irqPin | output | 1 | Level interrupt (pin mode) |
| msgIrq | output | NUM_VEC | Per-vector one-cycle interrupt pulses (message mode) |
| dropErr | output | 1 | Sticky flag: an out-of-range doorbell was dropped |

## Verification
Some properties are checked by assertions on every cycle:
- an accepted pin event leaves the status flag set;
- a status read with no competing event leaves it clear;
- no outgoing pulse appears without an accepted doorbell write;
- the error flag never falls;
- at most one vector pulse is active at a time;
- message-mode events leave the status flag alone.

Some behaviour only the bench scenarios can show:
- the exact read values of the identity word around the ready transition;
- the collision between a status read and an incoming event;
- the mask bits above bit 0 having no effect;
- the boundary vectors `NUM_VEC`-1 and `NUM_VEC` in both modes;
- the correct destination and vector fields on the outgoing event.

// File: rtl/bell_pkg.sv
package bell_pkg;

  localparam int DATA_W = 32;
  localparam int FIELD_W = 16;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_IDENT  = 2'd2,
    SEL_BELL   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrMask;     // load mask word
    logic rdStatus;   // status read: clear after this edge
    logic setStatus;  // pin-mode incoming event
    logic bellFire;   // accepted doorbell write
    logic bellDrop;   // rejected doorbell write
    logic msgFire;    // in-range message-mode incoming event
  } bellStrb_t;

endpackage

// File: rtl/bell_ctrl.sv
module bell_ctrl
  import bell_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgMode,
  input  logic [1:0]         busWordSel,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [FIELD_W-1:0] bellVec,
  input  logic               inValid,
  input  logic [FIELD_W-1:0] inVector,
  output bellStrb_t          strb
);

  localparam logic [FIELD_W:0] VEC_LIMIT = (FIELD_W+1)'(NUM_VEC);

  regSel_e sel;
  logic    bellWrite;
  logic    bellInRange;
  logic    inInRange;

  assign sel         = regSel_e'(busWordSel);
  assign bellWrite   = busWrEn && (sel == SEL_BELL);
  assign bellInRange = {1'b0, bellVec} < VEC_LIMIT;
  assign inInRange   = {1'b0, inVector} < VEC_LIMIT;

  always_comb begin
    strb           = '0;
    strb.wrMask    = busWrEn && (sel == SEL_MASK);
    strb.rdStatus  = busRdEn && (sel == SEL_STATUS);
    strb.setStatus = inValid && !msgMode;
    strb.msgFire   = inValid && msgMode && inInRange;
    // pin mode: low field is don't-care, any write goes out
    strb.bellFire  = bellWrite && (!msgMode || bellInRange);
    strb.bellDrop  = bellWrite && msgMode && !bellInRange;
  end

  AST_FIRE_XOR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.bellFire && strb.bellDrop)); // R8

endmodule

// File: rtl/bell_dpath.sv
module bell_dpath
  import bell_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgMode,
  input  bellStrb_t          strb,
  input  logic [1:0]         busWordSel,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [FIELD_W-1:0] inVector,
  input  logic               devReady,
  input  logic [FIELD_W-1:0] selfId,
  output logic [DATA_W-1:0]  busRdata,
  output logic               outValid,
  output logic [FIELD_W-1:0] outDestId,
  output logic [FIELD_W-1:0] outVector,
  output logic               irqPin,
  output logic [NUM_VEC-1:0] msgIrq,
  output logic               dropErr
);

  logic [DATA_W-1:0] maskQ;
  logic              statusQ;
  logic              errQ;
  logic              outValidQ;
  logic [FIELD_W-1:0] destQ;
  logic [FIELD_W-1:0] vecQ;
  logic [NUM_VEC-1:0] pulseQ;

  // mask word: all bits stored, only bit 0 gates the pin
  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.wrMask) maskQ <= busWdata;
  end

  // status flag: incoming event wins over clear-on-read
  always_ff @(posedge clk) begin
    if (!rstN)               statusQ <= 1'b0;
    else if (strb.setStatus) statusQ <= 1'b1;
    else if (strb.rdStatus)  statusQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              errQ <= 1'b0;
    else if (strb.bellDrop) errQ <= 1'b1;
  end

  // outgoing doorbell event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      destQ     <= '0;
      vecQ      <= '0;
    end else begin
      outValidQ <= strb.bellFire;
      if (strb.bellFire) begin
        destQ <= busWdata[DATA_W-1:FIELD_W];
        vecQ  <= busWdata[FIELD_W-1:0];
      end
    end
  end

  // per-vector message pulses
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) pulseQ[gi] <= 1'b0;
      else       pulseQ[gi] <= strb.msgFire && (inVector == FIELD_W'(gi));
    end
  end

  always_comb begin
    unique case (regSel_e'(busWordSel))
      SEL_MASK:   busRdata = maskQ;
      SEL_STATUS: busRdata = {{(DATA_W-1){1'b0}}, statusQ};
      SEL_IDENT:  busRdata = devReady ? {{(DATA_W-FIELD_W){1'b0}}, selfId} : '1;
      default:    busRdata = '0;
    endcase
  end

  assign irqPin    = !msgMode && maskQ[0] && statusQ;
  assign outValid  = outValidQ;
  assign outDestId = destQ;
  assign outVector = vecQ;
  assign msgIrq    = pulseQ;
  assign dropErr   = errQ;

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStatus |=> (busRdata == 32'd1 || regSel_e'(busWordSel) != SEL_STATUS) && statusQ); // R2
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStatus && !strb.setStatus) |=> !statusQ); // R9
  AST_NO_STRAY_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.bellFire |=> !outValid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    dropErr |=> dropErr); // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(msgIrq)); // R4
  AST_MSG_NO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (msgMode && !strb.rdStatus) |=> $stable(statusQ)); // R4

endmodule

// File: rtl/bell_regblock.sv
module bell_regblock
  import bell_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgMode,
  input  logic               devReady,
  input  logic [15:0]        selfId,
  input  logic [1:0]         busWordSel,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               outValid,
  output logic [15:0]        outDestId,
  output logic [15:0]        outVector,
  input  logic               inValid,
  input  logic [15:0]        inVector,
  output logic               irqPin,
  output logic [NUM_VEC-1:0] msgIrq,
  output logic               dropErr
);

  bellStrb_t strb;

  bell_ctrl #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .msgMode    (msgMode),
    .busWordSel (busWordSel),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .bellVec    (busWdata[FIELD_W-1:0]),
    .inValid    (inValid),
    .inVector   (inVector),
    .strb       (strb)
  );

  bell_dpath #(.NUM_VEC(NUM_VEC)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .msgMode    (msgMode),
    .strb       (strb),
    .busWordSel (busWordSel),
    .busWdata   (busWdata),
    .inVector   (inVector),
    .devReady   (devReady),
    .selfId     (selfId),
    .busRdata   (busRdata),
    .outValid   (outValid),
    .outDestId  (outDestId),
    .outVector  (outVector),
    .irqPin     (irqPin),
    .msgIrq     (msgIrq),
    .dropErr    (dropErr)
  );

endmodule

// File: tb/sim_bell_regblock.sv
`timescale 1ns/100ps
module sim_bell_regblock;

  localparam int NV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgMode = 1'b0;
  logic devReady = 1'b0;
  logic [15:0] selfId = 16'h0025;
  logic [1:0] busWordSel = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic outValid;
  logic [15:0] outDestId, outVector;
  logic inValid = 1'b0;
  logic [15:0] inVector = '0;
  logic irqPin;
  logic [NV-1:0] msgIrq;
  logic dropErr;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bell_regblock #(.NUM_VEC(NV)) u0 (.*);

  // behavioural reference state
  logic [31:0] mMask = '0;
  bit mStatus = 0, mErr = 0, mOutV = 0;
  logic [15:0] mDest = '0, mVec = '0;
  int mPulse = -1;

  function automatic logic [31:0] mRead(input logic [1:0] s);
    case (s)
      2'd0: return mMask;
      2'd1: return {31'd0, mStatus};
      2'd2: return devReady ? {16'd0, selfId} : 32'hFFFF_FFFF;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mMask = '0; mStatus = 0; mErr = 0; mOutV = 0; mDest = '0; mVec = '0; mPulse = -1;
    end else begin
      bit bell, ok;
      bell = busWrEn && busWordSel == 2'd3;
      ok = !msgMode || busWdata[15:0] < NV;
      mOutV = bell && ok;
      if (bell && ok) begin
        mDest = busWdata[31:16];
        mVec = busWdata[15:0];
      end
      if (bell && !ok) mErr = 1;
      mPulse = (inValid && msgMode && inVector < NV) ? int'(inVector) : -1;
      if (busWrEn && busWordSel == 2'd0) mMask = busWdata;
      if (inValid && !msgMode) mStatus = 1;
      else if (busRdEn && busWordSel == 2'd1) mStatus = 0;
    end
  end

  // every-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rstN) begin
      logic [NV-1:0] expPulse;
      expPulse = '0;
      if (mPulse >= 0) expPulse[mPulse] = 1'b1;
      chk(irqPin == (!msgMode && mMask[0] && mStatus), "R3 irqPin", 32'(irqPin),
          32'(!msgMode && mMask[0] && mStatus));
      chk(outValid == mOutV, "R6 outValid", 32'(outValid), 32'(mOutV));
      if (mOutV) begin
        chk(outDestId == mDest, "R6 outDestId", 32'(outDestId), 32'(mDest));
        chk(outVector == mVec, "R7 outVector", 32'(outVector), 32'(mVec));
      end
      chk(msgIrq == expPulse, "R4 msgIrq", 32'(msgIrq), 32'(expPulse));
      chk(dropErr == mErr, "R8 dropErr", 32'(dropErr), 32'(mErr));
    end
  end

  task automatic step(input bit wr, input bit rd, input logic [1:0] s, input logic [31:0] wd,
                      input bit iv, input logic [15:0] ivec, input string tag);
    @(negedge clk);
    #0.5;
    busWrEn = wr; busRdEn = rd; busWordSel = s; busWdata = wd;
    inValid = iv; inVector = ivec;
    if (rd) begin
      #1;
      chk(busRdata === mRead(s), tag, busRdata, mRead(s));
    end
  endtask

  task automatic idle();
    step(0, 0, 2'd0, 32'd0, 0, 16'd0, "");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5 rstN = 1'b1;
    @(negedge clk);
    chk({irqPin, outValid, dropErr, msgIrq} == '0, "R1 outputs after reset",
        32'({irqPin, outValid, dropErr, msgIrq}), 32'd0);
    step(0, 1, 2'd0, 0, 0, 0, "R1 mask reset");
    step(0, 1, 2'd1, 0, 0, 0, "R1 status reset");

    // pin mode
    step(0, 0, 2'd0, 0, 1, 16'h0007, "");
    step(0, 1, 2'd0, 0, 0, 0, "R2 status untouched read of mask");
    step(1, 0, 2'd0, 32'hFFFF_FFFE, 0, 0, "");           // R3: upper mask bits only
    step(0, 1, 2'd0, 0, 0, 0, "R3 mask readback");
    step(1, 0, 2'd0, 32'h0000_0001, 0, 0, "");           // R3: unmask
    idle();
    step(0, 1, 2'd1, 0, 0, 0, "R2 status reads 1");      // also clears
    step(0, 1, 2'd1, 0, 0, 0, "R9 status cleared by read");
    step(0, 1, 2'd1, 0, 1, 16'h1234, "R9 read with event");
    step(0, 1, 2'd1, 0, 0, 0, "R9 event wins over clear");
    step(0, 0, 2'd0, 0, 1, 16'hFFFF, "");
    step(1, 0, 2'd1, 32'h0, 0, 0, "");                   // R10: write status
    step(0, 1, 2'd3, 0, 0, 0, "R10 bell reads 0");
    step(0, 1, 2'd1, 0, 0, 0, "R10 status unchanged by write");

    // identity
    step(0, 1, 2'd2, 0, 0, 0, "R5 not ready");
    step(1, 0, 2'd2, 32'h0000_1111, 0, 0, "");
    @(negedge clk); #0.5 devReady = 1'b1;
    step(0, 1, 2'd2, 0, 0, 0, "R5 ready id");

    // doorbell, pin mode: any vector accepted
    step(1, 0, 2'd3, 32'h0003_BEEF, 0, 0, "");
    step(1, 0, 2'd3, 32'h0005_0001, 0, 0, "");
    idle();
    idle();

    // message mode
    step(0, 0, 2'd0, 0, 1, 16'h0002, "");
    @(negedge clk); #0.5 msgMode = 1'b1; inValid = 1'b0;
    step(0, 0, 2'd0, 0, 1, 16'h0002, "");
    step(0, 0, 2'd0, 0, 1, 16'(NV-1), "");
    step(0, 0, 2'd0, 0, 1, 16'(NV), "");
    idle();
    step(0, 1, 2'd1, 0, 0, 0, "R4 status untouched in message mode");
    step(1, 0, 2'd3, {16'h0009, 16'(NV-1)}, 0, 0, "");
    step(1, 0, 2'd3, {16'h0009, 16'(NV)}, 0, 0, "");
    idle();
    step(1, 0, 2'd3, 32'h000A_0000, 0, 0, "");
    idle();
    @(negedge clk);
    chk(dropErr == 1'b1, "R8 sticky after later writes", 32'(dropErr), 32'd1);

    // back to pin mode: out-of-range vector accepted
    @(negedge clk); #0.5 msgMode = 1'b0;
    step(1, 0, 2'd3, 32'h0007_FFFF, 0, 0, "");
    idle();
    idle();

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 5000) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=%0d exp=<5000", cycles);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule